// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Core

This core gathers eight interrupt request lines from asynchronous sources and presents one interrupt line to a processor. Each request line is brought into the clock domain before it is captured in a request register. Capture is either by rising edge or by level. A mask register hides selected levels from the priority logic. A fixed-priority resolver then finds the most urgent visible request. It raises the interrupt output only when that request outranks every level the processor is already servicing.

An acknowledge strobe hands the winning level to the processor on a three-bit level output. In the same clock edge it moves that level from the request register into the in-service register. Service ends in one of three ways: a non-specific end-of-interrupt command, a specific end-of-interrupt command that names a level, or automatic end-of-interrupt, which leaves the in-service register untouched on acknowledge. The request, in-service and mask registers can all be read directly.

Top module: `prio_irq_core`

## Requirements
- R1: After reset, irq_o is 0, level_o is 0, and req_o, isr_o and mask_o are all 0.
- R2: With level_mode_i=0, a rising edge on irq_i[n] sets req_o[n] on the third clock edge after the change. If the line falls again before acknowledge, req_o[n] clears and the request is lost.
- R3: With level_mode_i=1, req_o[n] follows the synchronized irq_i[n]. A request cleared by acknowledge comes back while the line stays high.
- R4: Bit n of mask_o set to 1 (written through mask_we_i and mask_wdata_i) keeps level n out of priority resolution. req_o still shows the masked bit, and lower-priority unmasked levels can still raise irq_o.
- R5: Priority is fixed: level 0 is the highest and level 7 the lowest. irq_o is 1 exactly when an unmasked pending level exists and no in-service bit has equal or higher priority.
- R6: An ack_i pulse while irq_o=1 and auto_eoi_i=0 sets isr_o at the winning level, clears the matching req_o bit, and loads level_o with the winning level number.
- R7: An ack_i pulse while irq_o=0 loads level_o with 7 (spurious) and leaves isr_o and req_o unchanged.
- R8: eoi_i with eoi_specific_i=0 clears the highest-priority set bit of isr_o.
- R9: eoi_i with eoi_specific_i=1 clears isr_o[eoi_level_i].
- R10: With auto_eoi_i=1, acknowledge clears the winning request bit and reports the level on level_o, but leaves isr_o unchanged.
- R11: A pending level with equal or lower priority than the highest in-service level keeps irq_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Asynchronous interrupt request lines |
| level_mode_i | input | 1 | 1 = level capture, 0 = edge capture |
| auto_eoi_i | input | 1 | 1 = automatic end-of-interrupt on acknowledge |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data, 1 = level masked |
| ack_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt command strobe |
| eoi_specific_i | input | 1 | 1 = clear the named level, 0 = clear the highest in-service level |
| eoi_level_i | input | 3 | Level cleared by a specific end-of-interrupt |
| irq_o | output | 1 | Interrupt output to the processor |
| level_o | output | 3 | Level granted by the last acknowledge, 7 if spurious |
| req_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |

## Verification
The hardest situation to reach is a nested service: a low level is in service, a still lower level is pending (so irq_o must stay low), and then a higher level arrives and must preempt. The stimulus reaches it by acknowledging level 4 and then raising level 6, checking that irq_o stays low. It then raises level 1, acknowledges it, and retires both levels in turn with non-specific and specific end-of-interrupt commands. A second hard case is a request that disappears before it is acknowledged. The stimulus makes an edge request fall after capture and checks that the request register empties again.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DEF_LVLS = 8;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_LVL = pic_pkg::DEF_LVLS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic [NUM_LVL-1:0] clr_i,
  output logic [NUM_LVL-1:0] req_o
);
  logic [NUM_LVL-1:0] req_q;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
    logic meta_q, sync_q, prev_q, rise;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= irq_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise = sync_q & ~prev_q;

    // edge request survives only while the line stays high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q[g] <= 1'b0;
      else if (level_mode_i) req_q[g] <= sync_q & ~clr_i[g];
      else req_q[g] <= (req_q[g] | rise) & sync_q & ~clr_i[g];
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/prio_find.sv
module prio_find #(
  parameter int unsigned NUM_LVL = pic_pkg::DEF_LVLS,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] vec_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LVL_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
  parameter int unsigned NUM_LVL = pic_pkg::DEF_LVLS,
  localparam int unsigned LVL_W = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic               auto_eoi_i,
  input  logic               mask_we_i,
  input  logic [NUM_LVL-1:0] mask_wdata_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic               eoi_specific_i,
  input  logic [LVL_W-1:0]   eoi_level_i,
  output logic               irq_o,
  output logic [LVL_W-1:0]   level_o,
  output logic [NUM_LVL-1:0] req_o,
  output logic [NUM_LVL-1:0] isr_o,
  output logic [NUM_LVL-1:0] mask_o
);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NUM_LVL - 1);

  logic [NUM_LVL-1:0] req, pend, isr_q, mask_q, grant_vec, eoi_vec;
  logic [LVL_W-1:0]   pend_lvl, isr_lvl, level_q;
  logic               pend_any, isr_any, irq, grant;

  irq_capture #(.NUM_LVL(NUM_LVL)) i_capture (
    .clk_i, .rst_ni, .irq_i, .level_mode_i,
    .clr_i(grant_vec), .req_o(req)
  );

  assign pend = req & ~mask_q;

  prio_find #(.NUM_LVL(NUM_LVL)) i_pend_find (
    .vec_i(pend), .any_o(pend_any), .idx_o(pend_lvl)
  );
  prio_find #(.NUM_LVL(NUM_LVL)) i_isr_find (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_lvl)
  );

  // strictly higher priority (lower index) than anything in service
  assign irq   = pend_any && (!isr_any || pend_lvl < isr_lvl);
  assign grant = ack_i && irq;

  always_comb begin
    grant_vec = '0;
    if (grant) grant_vec[pend_lvl] = 1'b1;
    eoi_vec = '0;
    if (eoi_i) begin
      if (eoi_specific_i) eoi_vec[eoi_level_i] = 1'b1;
      else if (isr_any) eoi_vec[isr_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q   <= '0;
      mask_q  <= '0;
      level_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_vec) | (auto_eoi_i ? '0 : grant_vec);
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (ack_i) level_q <= grant ? pend_lvl : SPUR_LVL;
    end
  end

  assign irq_o   = irq;
  assign level_o = level_q;
  assign req_o   = req;
  assign isr_o   = isr_q;
  assign mask_o  = mask_q;

  p_grant_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o && !auto_eoi_i |=> isr_o[level_o]);
  p_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o && !eoi_i |=> level_o == SPUR_LVL && $stable(isr_o));
  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & ~mask_o) == '0 |-> !irq_o);
  p_auto_eoi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && auto_eoi_i && !eoi_i |=> $stable(isr_o));
  p_eoi_one_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i && !eoi_specific_i && !ack_i && isr_o != '0
    |=> $countones(isr_o) == $countones($past(isr_o)) - 1);
  p_isr_no_lower_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !isr_o[pend_lvl]);
endmodule

// File: tb/test_prio_irq_core.sv
`timescale 1ns/1ps
module test_prio_irq_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       level_mode = 1'b0, auto_eoi = 1'b0, mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       ack = 1'b0, eoi = 1'b0, eoi_spec = 1'b0;
  logic [2:0] eoi_lvl = '0;
  logic       irq_out;
  logic [2:0] level;
  logic [7:0] req, isr, mask;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_core i_prio_irq_core (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .level_mode_i(level_mode),
    .auto_eoi_i(auto_eoi), .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .ack_i(ack), .eoi_i(eoi), .eoi_specific_i(eoi_spec), .eoi_level_i(eoi_lvl),
    .irq_o(irq_out), .level_o(level), .req_o(req), .isr_o(isr), .mask_o(mask)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic do_eoi(bit spec, logic [2:0] lvl);
    eoi = 1'b1; eoi_spec = spec; eoi_lvl = lvl; cyc(1);
    eoi = 1'b0; eoi_spec = 1'b0; eoi_lvl = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", {7'b0, irq_out}, 8'h00);
    check("R1 level", {5'b0, level}, 8'h00);
    check("R1 req", req, 8'h00);
    check("R1 isr", isr, 8'h00);
    check("R1 mask", mask, 8'h00);
  endtask

  task automatic t_edge();
    level_mode = 1'b0;
    irq[3] = 1'b1; cyc(4);
    check("R2 req set", req, 8'h08);
    check("R5 irq up", {7'b0, irq_out}, 8'h01);
    do_ack();
    check("R6 level", {5'b0, level}, 8'h03);
    check("R6 isr", isr, 8'h08);
    check("R6 req clr", req, 8'h00);
    irq[3] = 1'b0;
    do_eoi(1'b0, 3'd0);
    check("R8 isr clr", isr, 8'h00);
    irq[5] = 1'b1; cyc(4);
    check("R2 req5", req, 8'h20);
    irq[5] = 1'b0; cyc(4);
    check("R2 dropped", req, 8'h00);
    check("R2 irq low", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_level();
    level_mode = 1'b1;
    irq[2] = 1'b1; cyc(4);
    check("R3 req", req, 8'h04);
    do_ack();
    check("R6 level2", {5'b0, level}, 8'h02);
    check("R6 isr2", isr, 8'h04);
    cyc(3);
    check("R3 reassert", req, 8'h04);
    check("R11 equal blocked", {7'b0, irq_out}, 8'h00);
    irq[2] = 1'b0; cyc(4);
    check("R3 follows low", req, 8'h00);
    do_eoi(1'b0, 3'd0);
    check("R8 isr empty", isr, 8'h00);
  endtask

  task automatic t_mask();
    level_mode = 1'b1;
    mask_we = 1'b1; mask_wdata = 8'h02; cyc(1); mask_we = 1'b0;
    check("R4 mask read", mask, 8'h02);
    irq[1] = 1'b1; irq[6] = 1'b1; cyc(4);
    check("R4 req shows masked", req, 8'h42);
    check("R4 lower still irq", {7'b0, irq_out}, 8'h01);
    do_ack();
    check("R4 winner unmasked", {5'b0, level}, 8'h06);
    check("R4 isr6", isr, 8'h40);
    do_eoi(1'b1, 3'd6);
    check("R9 specific clr", isr, 8'h00);
    irq = '0;
    mask_we = 1'b1; mask_wdata = 8'h00; cyc(1); mask_we = 1'b0;
    cyc(4);
    check("R4 cleanup", req, 8'h00);
  endtask

  task automatic t_nest();
    level_mode = 1'b1;
    irq[4] = 1'b1; cyc(4);
    do_ack();
    check("R6 isr4", isr, 8'h10);
    irq[6] = 1'b1; cyc(4);
    check("R11 lower blocked", {7'b0, irq_out}, 8'h00);
    irq[1] = 1'b1; cyc(4);
    check("R5 higher preempts", {7'b0, irq_out}, 8'h01);
    do_ack();
    check("R5 level1", {5'b0, level}, 8'h01);
    check("R6 nested isr", isr, 8'h12);
    do_eoi(1'b0, 3'd0);
    check("R8 highest only", isr, 8'h10);
    do_eoi(1'b1, 3'd4);
    check("R9 level4 clr", isr, 8'h00);
    irq = '0; cyc(4);
    check("R3 idle", req, 8'h00);
  endtask

  task automatic t_spurious();
    do_ack();
    check("R7 spurious level", {5'b0, level}, 8'h07);
    check("R7 isr untouched", isr, 8'h00);
    check("R7 req untouched", req, 8'h00);
  endtask

  task automatic t_auto_eoi();
    level_mode = 1'b0; auto_eoi = 1'b1;
    irq[0] = 1'b1; cyc(4);
    do_ack();
    check("R10 level0", {5'b0, level}, 8'h00);
    check("R10 isr unchanged", isr, 8'h00);
    check("R10 req clr", req, 8'h00);
    auto_eoi = 1'b0; irq = '0; cyc(4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_edge();
    t_level();
    t_mask();
    t_nest();
    t_spurious();
    t_auto_eoi();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule